// File: doc/BRIEF.md
# Flash Page-Buffer Write Controller

This block sits between a CPU-side byte port and a page-programmable non-volatile array, which is modelled here in registers. The array window covers addresses 0x4000 through 0xFFFF. That is 384 pages of 128 bytes, 49152 bytes in all. Reads in the window always return the stored byte, in any mode.

Writes are honoured only while the programming-mode input is high. An accepted write lands in a 128-byte staging buffer, not in the array. The first accepted byte fixes the target page. Once every one of the 128 byte slots has been written, the block starts a combined erase-and-program cycle on its own. That cycle replaces the whole target page, so no separate erase step exists.

The cycle length is counted in pulses of a timer-clock enable, not in system clocks. While the cycle runs, the block reports busy, rejects further writes and flags them in a sticky error bit. Only the first MODEL_PAGES pages are stored; MODEL_PAGES must be a power of two. The rest of the window decodes normally but reads as erased.

Top module: `flash_page_writer`

## Requirements
- R1: For an address from 0x4000 to 0xFFFF, the page number is (addr >> 7) - 128 and the byte slot is addr[6:0]. `rdata` returns that byte of a stored page, or 0xFF for a page at or above MODEL_PAGES. Outside the window, `rdata` is 0x00. After reset every stored byte reads 0xFF.
- R2: While `prog_mode` is low, writes neither fill the buffer nor set the error bit.
- R3: The first accepted write after the buffer empties fixes the target page. A second write to an already filled slot replaces that byte without counting toward a full buffer.
- R4: After the clock edge that accepts the write filling the last empty slot, `busy` reads 1.
- R5: `busy` stays high for exactly COMMIT_TICKS clock edges on which `tick_en` is high. It falls at the edge of the last such pulse, and cycles without `tick_en` do not advance the count.
- R6: When the cycle ends, all 128 bytes of the target page take the buffer contents. Until then, reads of that page return the old contents.
- R7: A write arriving while `busy` is high is dropped and sets `wr_err`.
- R8: A write to a different page while the buffer is partly filled is dropped and sets `wr_err`.
- R9: `wr_err` stays set until reset. Reset clears `busy`, `wr_err` and the buffer, and erases the stored pages.
- R10: Writes to addresses below 0x4000 are ignored and do not set `wr_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_mode | input | 1 | High enables writes to the window |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 16 | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| tick_en | input | 1 | Timer-clock enable that paces the commit cycle |
| rdata | output | 8 | Read data for `addr` (combinational) |
| busy | output | 1 | Commit cycle in progress |
| wr_err | output | 1 | Sticky flag for a rejected write |

## Verification
The main function is driven in three slot orders: ascending, descending, and odd slots first then even. Each order ends full on a different slot, so a fill tracker that merely counts up to slot 127 cannot pass all three. Overwriting a previously programmed page separates a page replacement from a merge into the old bytes. A commit to a page above the stored range shows that the decode and the completion logic still work there. Rewriting a slot, switching page mid-fill and writing while busy are each followed by a partial refill. That refill stops exactly one slot short of full, so a byte that was wrongly accepted would show up as a premature `busy`.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int ADDR_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int PAGE_BYTES = 128;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = ADDR_W - IDX_W;
  localparam logic [ADDR_W-1:0] WIN_BASE = 16'h4000;
  localparam logic [PAGE_W-1:0] BASE_PAGE = PAGE_W'(WIN_BASE >> IDX_W);

  function automatic logic win_hit(input logic [ADDR_W-1:0] a);
    return a >= WIN_BASE;
  endfunction

  function automatic logic [PAGE_W-1:0] page_num(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W] - BASE_PAGE;
  endfunction

  function automatic logic [IDX_W-1:0] byte_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/fpw_decode.sv
module fpw_decode
  import fpw_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    in_win = win_hit(addr);
    page   = page_num(addr);
    idx    = byte_idx(addr);
  end
endmodule

// File: rtl/fpw_fill.sv
module fpw_fill
  import fpw_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic [PAGE_W-1:0]            page,
  input  logic [IDX_W-1:0]             idx,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic                         clear,
  output logic                         empty,
  output logic                         full_evt,
  output logic [PAGE_W-1:0]            buf_page,
  output logic [PAGE_BYTES*BYTE_W-1:0] buf_flat
);
  logic [PAGE_BYTES-1:0] filled_q;
  logic [PAGE_BYTES-1:0] filled_nxt;

  always_comb begin
    filled_nxt = filled_q | (PAGE_BYTES'(1) << idx);
    full_evt   = accept && (&filled_nxt);
    empty      = ~|filled_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filled_q <= '0;
      buf_page <= '0;
      buf_flat <= '0;
    end else if (clear) begin
      filled_q <= '0;
    end else if (accept) begin
      filled_q <= filled_nxt;
      buf_flat[idx*BYTE_W +: BYTE_W] <= wdata;
      if (empty) buf_page <= page;
    end
  end
endmodule

// File: rtl/fpw_timer.sv
module fpw_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick_en,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  assign done = busy && tick_en && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy && tick_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpw_array.sv
module fpw_array
  import fpw_pkg::*;
#(
  parameter int MODEL_PAGES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [PAGE_W-1:0]            commit_page,
  input  logic [PAGE_BYTES*BYTE_W-1:0] buf_flat,
  input  logic                         rd_in_win,
  input  logic [PAGE_W-1:0]            rd_page,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [BYTE_W-1:0]            rdata
);
  localparam int MPW   = (MODEL_PAGES > 1) ? $clog2(MODEL_PAGES) : 1;
  localparam int CELLS = MODEL_PAGES * PAGE_BYTES;
  localparam int MW    = MPW + IDX_W;

  logic [BYTE_W-1:0] mem_q [CELLS];
  logic commit_hit;
  logic rd_hit;

  assign commit_hit = commit && (int'(commit_page) < MODEL_PAGES);
  assign rd_hit     = int'(rd_page) < MODEL_PAGES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) mem_q[i] <= 8'hFF;
    end else if (commit_hit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        mem_q[MW'({commit_page[MPW-1:0], IDX_W'(i)})] <= buf_flat[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    if (!rd_in_win)  rdata = 8'h00;
    else if (rd_hit) rdata = mem_q[MW'({rd_page[MPW-1:0], rd_idx})];
    else             rdata = 8'hFF;
  end
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int COMMIT_TICKS = 16,
  parameter int MODEL_PAGES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick_en,
  output logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              wr_err
);
  logic                         in_win;
  logic [PAGE_W-1:0]            page;
  logic [IDX_W-1:0]             idx;
  logic                         empty;
  logic                         full_evt;
  logic [PAGE_W-1:0]            buf_page;
  logic [PAGE_BYTES*BYTE_W-1:0] buf_flat;
  logic                         commit_done;
  logic                         wr_try;
  logic                         page_clash;
  logic                         wr_ok;
  logic                         wr_reject;

  fpw_decode u_dec (.addr(addr), .in_win(in_win), .page(page), .idx(idx));

  assign wr_try     = wr_en && prog_mode && in_win;
  assign page_clash = !empty && (page != buf_page);
  assign wr_ok      = wr_try && !busy && !page_clash;
  assign wr_reject  = wr_try && (busy || page_clash);

  fpw_fill u_fill (
    .clk(clk), .rst_n(rst_n), .accept(wr_ok), .page(page), .idx(idx),
    .wdata(wdata), .clear(commit_done), .empty(empty), .full_evt(full_evt),
    .buf_page(buf_page), .buf_flat(buf_flat)
  );

  fpw_timer #(.TICKS(COMMIT_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(full_evt), .tick_en(tick_en),
    .busy(busy), .done(commit_done)
  );

  fpw_array #(.MODEL_PAGES(MODEL_PAGES)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit_done), .commit_page(buf_page),
    .buf_flat(buf_flat), .rd_in_win(in_win), .rd_page(page), .rd_idx(idx),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         wr_err <= 1'b0;
    else if (wr_reject) wr_err <= 1'b1;
  end
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker (
  input logic clk,
  input logic rst_n,
  input logic prog_mode,
  input logic tick_en,
  input logic in_win,
  input logic busy,
  input logic wr_err,
  input logic wr_ok,
  input logic wr_reject,
  input logic full_evt,
  input logic commit_done
);
  AST_NOPROG_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |-> !wr_ok); // R2
  AST_FULL_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> busy); // R4
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !busy); // R5
  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> busy); // R5
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ok); // R7
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> wr_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R9
  AST_OUTSIDE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> !(wr_ok || wr_reject)); // R10
endmodule

bind flash_page_writer fpw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .tick_en(tick_en),
  .in_win(in_win), .busy(busy), .wr_err(wr_err), .wr_ok(wr_ok),
  .wr_reject(wr_reject), .full_evt(full_evt), .commit_done(commit_done)
);

// File: tb/flash_page_writer_tb_top.sv
module flash_page_writer_tb_top;
  localparam int CT = 16;
  localparam int MP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wdata = 8'h00;
  logic tick_en = 1'b0;
  logic [7:0] rdata;
  logic busy;
  logic wr_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] shadow [MP][128];

  // page[18:10], seed[9:2], slot order[1:0]: 0 up, 1 down, 2 odd then even
  localparam logic [18:0] VEC [5] = '{
    {9'd0,   8'h11, 2'd0},
    {9'd7,   8'hA0, 2'd1},
    {9'd0,   8'h3C, 2'd2},
    {9'd383, 8'h5A, 2'd0},
    {9'd5,   8'h00, 2'd2}
  };

  flash_page_writer #(.COMMIT_TICKS(CT), .MODEL_PAGES(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .tick_en(tick_en), .rdata(rdata),
    .busy(busy), .wr_err(wr_err)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] pa(input int p, input int i);
    return {9'(p + 128), 7'(i)};
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  function automatic int slot(input int mode, input int k);
    if (mode == 0) return k;
    if (mode == 1) return 127 - k;
    return (k < 64) ? 2 * k + 1 : 2 * (k - 64);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < MP; p++)
      for (int i = 0; i < 128; i++) shadow[p][i] = 8'hFF;
  endtask

  task automatic finish_commit(input int p);
    for (int t = 0; t < CT; t++) tick();
    chk("R5 busy after last tick", 16'(busy), 16'd0);
  endtask

  task automatic show_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: actual hung expected done");
    show_summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R9 / R1: reset state and decode
    chk("R9 busy after reset", 16'(busy), 16'd0);
    chk("R9 err after reset", 16'(wr_err), 16'd0);
    rd(16'h4000, d); chk("R1 erased first byte", 16'(d), 16'h00FF);
    rd(16'hFFFF, d); chk("R1 unstored top byte", 16'(d), 16'h00FF);
    rd(16'h3FFF, d); chk("R1 outside window", 16'(d), 16'h0000);

    // R2: full page of writes with programming mode low
    for (int i = 0; i < 128; i++) wr(pa(1, i), 8'h42);
    chk("R2 no commit", 16'(busy), 16'd0);
    chk("R2 no error", 16'(wr_err), 16'd0);
    rd(pa(1, 0), d); chk("R2 page untouched", 16'(d), 16'h00FF);

    prog_mode = 1'b1;
    // R10: a whole page worth of writes below the window
    for (int i = 0; i < 128; i++) wr(16'h3F80 + 16'(i), 8'h24);
    chk("R10 no commit", 16'(busy), 16'd0);
    chk("R10 no error", 16'(wr_err), 16'd0);

    // Table walk: R3 R4 R5 R6
    for (int v = 0; v < 5; v++) begin
      int p;
      int mode;
      logic [7:0] seed;
      logic [7:0] old;
      p = int'(VEC[v][18:10]); seed = VEC[v][9:2]; mode = int'(VEC[v][1:0]);
      for (int k = 0; k < 127; k++) wr(pa(p, slot(mode, k)), pat(seed, slot(mode, k)));
      chk("R3 not full at 127", 16'(busy), 16'd0);
      wr(pa(p, slot(mode, 127)), pat(seed, slot(mode, 127)));
      chk("R4 busy after last slot", 16'(busy), 16'd1);
      old = (p < MP) ? shadow[p][5] : 8'hFF;
      rd(pa(p, 5), d); chk("R6 old data while busy", 16'(d), 16'(old));
      for (int t = 0; t < CT - 1; t++) tick();
      chk("R5 busy before last tick", 16'(busy), 16'd1);
      repeat (5) @(negedge clk);
      chk("R5 idle cycles hold", 16'(busy), 16'd1);
      tick();
      chk("R5 busy ends on last tick", 16'(busy), 16'd0);
      for (int i = 0; i < 128; i++) begin
        if (p < MP) shadow[p][i] = pat(seed, i);
        rd(pa(p, i), d);
        chk("R6 page contents", 16'(d), 16'((p < MP) ? pat(seed, i) : 8'hFF));
      end
    end
    chk("R9 no error so far", 16'(wr_err), 16'd0);

    // R3: rewriting a slot replaces the byte and does not count
    wr(pa(2, 0), 8'hAA);
    wr(pa(2, 0), 8'hBB);
    for (int i = 1; i < 127; i++) wr(pa(2, i), 8'(i));
    chk("R3 rewrite not counted", 16'(busy), 16'd0);
    wr(pa(2, 127), 8'h7F);
    chk("R4 full after last", 16'(busy), 16'd1);
    finish_commit(2);
    rd(pa(2, 0), d); chk("R3 latest byte kept", 16'(d), 16'h00BB);

    // R8: page switch while partly filled
    for (int i = 0; i < 10; i++) wr(pa(3, i), 8'(i + 1));
    chk("R8 err before clash", 16'(wr_err), 16'd0);
    wr(pa(4, 10), 8'hEE);
    chk("R8 err on clash", 16'(wr_err), 16'd1);
    for (int i = 10; i < 127; i++) wr(pa(3, i), 8'(i + 1));
    chk("R8 clash not counted", 16'(busy), 16'd0);
    wr(pa(3, 127), 8'h80);
    chk("R8 page 3 commits", 16'(busy), 16'd1);
    finish_commit(3);
    rd(pa(4, 10), d); chk("R8 other page untouched", 16'(d), 16'h00FF);
    rd(pa(3, 10), d); chk("R8 target byte", 16'(d), 16'h000B);
    chk("R9 err sticky", 16'(wr_err), 16'd1);

    // R9: reset clears error and erases
    do_reset();
    chk("R9 err cleared", 16'(wr_err), 16'd0);
    rd(pa(3, 10), d); chk("R9 erased by reset", 16'(d), 16'h00FF);

    // R7: write while busy
    for (int i = 0; i < 128; i++) wr(pa(6, i), 8'h10);
    chk("R4 busy page 6", 16'(busy), 16'd1);
    wr(pa(6, 0), 8'h77);
    chk("R7 err on busy write", 16'(wr_err), 16'd1);
    finish_commit(6);
    for (int i = 1; i < 128; i++) wr(pa(6, i), 8'h20);
    chk("R7 busy write dropped", 16'(busy), 16'd0);
    wr(pa(6, 0), 8'h21);
    chk("R7 full after slot 0", 16'(busy), 16'd1);
    finish_commit(6);
    rd(pa(6, 0), d); chk("R7 slot 0 value", 16'(d), 16'h0021);
    chk("R9 err still set", 16'(wr_err), 16'd1);

    show_summary();
    $finish;
  end
endmodule